// File: doc/BRIEF.md
# Eight-Channel Load Switch Gate Control

This block decides, every clock cycle, which of eight power-switch gates are driven and which of the eight open-load sensing current sources are switched on. It holds a command word written by a neighbouring serial block. The word carries one on/off bit and one sensing-current bit per channel. It combines that word with two direct pulse-width inputs, a device enable, three supply-status flags and one over-temperature flag per channel.

Sleep covers enable low, loss of the logic supply, under-voltage and reset. In sleep the block wipes its command word and drops everything. When sleep ends it waits a fixed wake-up time, counted in clock cycles, before it accepts commands or drives any output. Over-voltage keeps the command word and only holds every gate off. When the flag clears, the gates return to the stored command. Over-temperature acts the same way, but only on its own channel.

Top module: `lsw_out_ctrl`

## Requirements
- R1: While `rst` is high, `enable_in` is low, `vdd_lost` is high or `uv_flag` is high, the registered outputs read `gate_en`=0, `olc_en`=0 and `ready`=0 from the next rising edge on.
- R2: After sleep ends, `ready` goes high on the READY_CYCLES-th rising edge with no sleep condition present. READY_CYCLES = CLK_FREQ_HZ/1e6 × READY_US. Before that edge `gate_en` and `olc_en` stay 0.
- R3: A `cmd_load` pulse while `ready` is low is ignored. The outputs stay 0 after ready rises.
- R4: `cmd_word` bit i (i < N_OUT) commands gate i on. Bit N_OUT+i enables sensing current i. A word loaded at edge k reaches `gate_en`/`olc_en` at edge k+1.
- R5: Gate PWM_BASE+j (channels 4 and 5 by default) is driven by its command bit OR `pwm_direct[j]`. No other gate reacts to `pwm_direct`.
- R6: Sleep clears the command word. After the wake-up time all gates and sensing currents stay off until a new word is loaded.
- R7: `ov_flag` high forces every gate off at the next edge. Sensing currents follow the command. When the flag clears, the gates return to the stored command at the next edge, with no new load.
- R8: `ot_flag[i]` turns off only gate i at the next edge. The gate returns when the flag clears, unless a word with bit i = 0 was loaded meanwhile.
- R9: Priority, highest first: sleep, then over-voltage, then over-temperature, then command OR PWM. Over-voltage also overrides the PWM inputs.
- R10: A sleep condition lasting one cycle restarts the full wake-up count and clears the command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, treated as sleep |
| enable_in | input | 1 | Device enable; low means sleep |
| vdd_lost | input | 1 | Logic supply missing |
| uv_flag | input | 1 | Under-voltage on a supply |
| ov_flag | input | 1 | Over-voltage on the power supply |
| ot_flag | input | N_OUT | Per-channel over-temperature |
| pwm_direct | input | N_PWM | Direct pulse-width inputs for channels PWM_BASE upward |
| cmd_load | input | 1 | Load strobe for `cmd_word` |
| cmd_word | input | 2*N_OUT | Upper half: sensing-current enables; lower half: gate commands |
| ready | output | 1 | Wake-up time elapsed, commands accepted |
| gate_en | output | N_OUT | Registered gate drive per channel |
| olc_en | output | N_OUT | Registered open-load sensing current enable per channel |

## Verification
The bench loads all 256 gate patterns and crosses the direct inputs with several command words. It steps over-temperature across each channel in turn and runs over-voltage cycles against a stored word. It also tries loads during wake-up and sleep pulses of a single cycle.

Each of these catches a specific error:
- A design that cleared the command word on over-voltage would leave gates dark after the flag drops.
- One that kept the word across sleep would turn loads on again after wake-up.
- An off-by-one in the wake-up counter would raise `ready` one edge early or late.
- A PWM input wired to the wrong channel, or left ungated by over-voltage, would show up as a wrong gate bit.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic [1:0] {
    PWR_SLEEP = 2'd0,
    PWR_WAKE  = 2'd1,
    PWR_RUN   = 2'd2
  } pwr_state_e;

  function automatic logic is_sleep(input logic rst, input logic en,
                                    input logic vdd_lost, input logic uv);
    return rst | ~en | vdd_lost | uv;
  endfunction
endpackage

// File: rtl/lsw_por_timer.sv
module lsw_por_timer #(
  parameter int READY_CYCLES = 100,
  localparam int CNT_W = (READY_CYCLES < 2) ? 1 : $clog2(READY_CYCLES)
) (
  input  logic clk,
  input  logic sleep_i,
  output logic ready_o
);
  import lsw_pkg::*;

  pwr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (sleep_i) begin
      state_q <= PWR_SLEEP;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PWR_SLEEP, PWR_WAKE: begin
          if (cnt_q == CNT_W'(READY_CYCLES - 1)) begin
            state_q <= PWR_RUN;
          end else begin
            state_q <= PWR_WAKE;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= PWR_RUN;
      endcase
    end
  end

  assign ready_o = (state_q == PWR_RUN);
endmodule

// File: rtl/lsw_cmd_reg.sv
module lsw_cmd_reg #(
  parameter int N_OUT = 8
) (
  input  logic               clk,
  input  logic               sleep_i,
  input  logic               ready_i,
  input  logic               load_i,
  input  logic [2*N_OUT-1:0] word_i,
  output logic [N_OUT-1:0]   on_o,
  output logic [N_OUT-1:0]   olc_o
);
  logic [2*N_OUT-1:0] word_q;

  always_ff @(posedge clk) begin
    if (sleep_i)
      word_q <= '0;
    else if (load_i && ready_i)
      word_q <= word_i;
  end

  assign on_o  = word_q[N_OUT-1:0];
  assign olc_o = word_q[2*N_OUT-1:N_OUT];
endmodule

// File: rtl/lsw_gate_logic.sv
module lsw_gate_logic #(
  parameter int N_OUT    = 8,
  parameter int N_PWM    = 2,
  parameter int PWM_BASE = 4
) (
  input  logic             clk,
  input  logic             sleep_i,
  input  logic             ready_i,
  input  logic             ov_i,
  input  logic [N_OUT-1:0] ot_i,
  input  logic [N_OUT-1:0] on_i,
  input  logic [N_OUT-1:0] olc_i,
  input  logic [N_PWM-1:0] pwm_i,
  output logic [N_OUT-1:0] gate_o,
  output logic [N_OUT-1:0] olc_en_o
);
  logic [N_OUT-1:0] demand;

  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    if (i >= PWM_BASE && i < PWM_BASE + N_PWM) begin : g_pwm
      assign demand[i] = on_i[i] | pwm_i[i - PWM_BASE];
    end else begin : g_cmd
      assign demand[i] = on_i[i];
    end

    always_ff @(posedge clk) begin
      if (sleep_i || !ready_i) begin
        gate_o[i]   <= 1'b0;
        olc_en_o[i] <= 1'b0;
      end else begin
        gate_o[i]   <= !ov_i && !ot_i[i] && demand[i];
        olc_en_o[i] <= olc_i[i];
      end
    end
  end
endmodule

// File: rtl/lsw_out_ctrl.sv
module lsw_out_ctrl #(
  parameter int N_OUT       = 8,
  parameter int N_PWM       = 2,
  parameter int PWM_BASE    = 4,
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int READY_US    = 100,
  localparam int RAW_CYC      = (CLK_FREQ_HZ / 1_000_000) * READY_US,
  localparam int READY_CYCLES = (RAW_CYC < 1) ? 1 : RAW_CYC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_in,
  input  logic               vdd_lost,
  input  logic               uv_flag,
  input  logic               ov_flag,
  input  logic [N_OUT-1:0]   ot_flag,
  input  logic [N_PWM-1:0]   pwm_direct,
  input  logic               cmd_load,
  input  logic [2*N_OUT-1:0] cmd_word,
  output logic               ready,
  output logic [N_OUT-1:0]   gate_en,
  output logic [N_OUT-1:0]   olc_en
);
  import lsw_pkg::*;

  logic             sleep;
  logic [N_OUT-1:0] cmd_on;
  logic [N_OUT-1:0] cmd_olc;

  assign sleep = is_sleep(rst, enable_in, vdd_lost, uv_flag);

  lsw_por_timer #(.READY_CYCLES(READY_CYCLES)) u_timer (
    .clk     (clk),
    .sleep_i (sleep),
    .ready_o (ready)
  );

  lsw_cmd_reg #(.N_OUT(N_OUT)) u_cmd (
    .clk     (clk),
    .sleep_i (sleep),
    .ready_i (ready),
    .load_i  (cmd_load),
    .word_i  (cmd_word),
    .on_o    (cmd_on),
    .olc_o   (cmd_olc)
  );

  lsw_gate_logic #(.N_OUT(N_OUT), .N_PWM(N_PWM), .PWM_BASE(PWM_BASE)) u_gate (
    .clk      (clk),
    .sleep_i  (sleep),
    .ready_i  (ready),
    .ov_i     (ov_flag),
    .ot_i     (ot_flag),
    .on_i     (cmd_on),
    .olc_i    (cmd_olc),
    .pwm_i    (pwm_direct),
    .gate_o   (gate_en),
    .olc_en_o (olc_en)
  );
endmodule

// File: rtl/lsw_out_ctrl_chk.sv
module lsw_out_ctrl_chk #(
  parameter int N_OUT    = 8,
  parameter int N_PWM    = 2,
  parameter int PWM_BASE = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             enable_in,
  input logic             vdd_lost,
  input logic             uv_flag,
  input logic             ov_flag,
  input logic [N_OUT-1:0] ot_flag,
  input logic [N_PWM-1:0] pwm_direct,
  input logic             ready,
  input logic [N_OUT-1:0] gate_en,
  input logic [N_OUT-1:0] olc_en
);
  logic asleep;
  assign asleep = rst | ~enable_in | vdd_lost | uv_flag;

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    asleep |=> (gate_en == '0 && olc_en == '0 && !ready)); // R1
  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (gate_en == '0 && olc_en == '0)); // R2
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ready && !asleep) |=> ready); // R2
  AST_OV_OFF: assert property (@(posedge clk) disable iff (rst)
    ov_flag |=> (gate_en == '0)); // R7
  AST_OT_OWN_OFF: assert property (@(posedge clk) disable iff (rst)
    (ot_flag != '0) |=> ((gate_en & $past(ot_flag)) == '0)); // R8

  for (genvar j = 0; j < N_PWM; j++) begin : g_pwm_chk
    AST_PWM_DRIVES: assert property (@(posedge clk) disable iff (rst)
      (ready && !asleep && !ov_flag && !ot_flag[PWM_BASE+j] && pwm_direct[j])
      |=> gate_en[PWM_BASE+j]); // R5
  end
endmodule

bind lsw_out_ctrl lsw_out_ctrl_chk #(
  .N_OUT(N_OUT), .N_PWM(N_PWM), .PWM_BASE(PWM_BASE)
) chk_i (
  .clk(clk), .rst(rst), .enable_in(enable_in), .vdd_lost(vdd_lost),
  .uv_flag(uv_flag), .ov_flag(ov_flag), .ot_flag(ot_flag),
  .pwm_direct(pwm_direct), .ready(ready), .gate_en(gate_en), .olc_en(olc_en)
);

// File: tb/lsw_out_ctrl_tb_top.sv
module lsw_out_ctrl_tb_top;
  localparam int N  = 8;
  localparam int NP = 2;
  localparam int PB = 4;
  localparam int RC = 20; // 1 MHz x 20 us

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, enable_in = 1'b0, vdd_lost = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
  logic [N-1:0]  ot_flag = '0;
  logic [NP-1:0] pwm_direct = '0;
  logic          cmd_load = 1'b0;
  logic [2*N-1:0] cmd_word = '0;
  logic          ready;
  logic [N-1:0]  gate_en, olc_en;

  lsw_out_ctrl #(.N_OUT(N), .N_PWM(NP), .PWM_BASE(PB),
                 .CLK_FREQ_HZ(1_000_000), .READY_US(RC)) dut_i (
    .clk(clk), .rst(rst), .enable_in(enable_in), .vdd_lost(vdd_lost),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .ot_flag(ot_flag),
    .pwm_direct(pwm_direct), .cmd_load(cmd_load), .cmd_word(cmd_word),
    .ready(ready), .gate_en(gate_en), .olc_en(olc_en));

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // expectation state derived from the requirements
  logic [2*N-1:0] m_cmd = '0;
  logic           m_ready = 1'b0;
  int             m_cnt = 0;
  logic [N-1:0]   m_gate = '0, m_olc = '0;

  task automatic step();
    logic slp;
    logic [N-1:0] dem;
    logic [2*N-1:0] n_cmd;
    logic n_ready;
    int n_cnt;
    logic [N-1:0] n_gate, n_olc;
    slp = rst | ~enable_in | vdd_lost | uv_flag;
    dem = m_cmd[N-1:0] | (N'(pwm_direct) << PB);
    n_gate = (slp || !m_ready || ov_flag) ? '0 : (dem & ~ot_flag);
    n_olc  = (slp || !m_ready) ? '0 : m_cmd[2*N-1:N];
    n_cmd = slp ? '0 : ((cmd_load && m_ready) ? cmd_word : m_cmd);
    n_ready = m_ready; n_cnt = m_cnt;
    if (slp) begin n_ready = 0; n_cnt = 0; end
    else if (!m_ready) begin
      if (m_cnt == RC - 1) n_ready = 1; else n_cnt = m_cnt + 1;
    end
    @(posedge clk); #2;
    m_gate = n_gate; m_olc = n_olc; m_cmd = n_cmd; m_ready = n_ready; m_cnt = n_cnt;
    checks++;
    if (gate_en !== m_gate || olc_en !== m_olc || ready !== m_ready) begin
      errors++;
      $display("FAIL %s: gate=%h olc=%h ready=%b expected gate=%h olc=%h ready=%b",
               cur_req, gate_en, olc_en, ready, m_gate, m_olc, m_ready);
    end
  endtask

  task automatic load(input logic [2*N-1:0] w);
    cmd_word = w; cmd_load = 1'b1; step();
    cmd_load = 1'b0; step(); step();
  endtask

  task automatic wake();
    for (int k = 0; k < RC + 2; k++) step();
  endtask

  initial begin
    #2;
    // R1: reset and sleep state
    cur_req = "R1";
    for (int k = 0; k < 3; k++) step();
    rst = 1'b0;
    for (int k = 0; k < 3; k++) step();
    // R2 and R3: wake-up count with loads attempted during it
    cur_req = "R2/R3";
    enable_in = 1'b1; cmd_word = 16'hFFFF; cmd_load = 1'b1;
    for (int k = 0; k < RC - 1; k++) step();
    cmd_load = 1'b0;
    wake();
    // R4: every gate pattern, sensing bits inverted
    cur_req = "R4";
    for (int c = 0; c < 256; c++) load({~8'(c), 8'(c)});
    // R5: direct inputs crossed with commands
    cur_req = "R5";
    foreach (cmd_word[b]) begin end
    for (int w = 0; w < 4; w++) begin
      case (w)
        0: load(16'h0000);
        1: load(16'h0030);
        2: load(16'h00CF);
        default: load(16'h0010);
      endcase
      for (int p = 0; p < 4; p++) begin
        pwm_direct = 2'(p); step(); step();
      end
      pwm_direct = '0; step();
    end
    // R7: over-voltage keeps the stored command
    cur_req = "R7";
    load(16'h3CA5);
    ov_flag = 1'b1; step(); step(); step();
    ov_flag = 1'b0; step(); step();
    // R8: over-temperature per channel
    cur_req = "R8";
    load(16'h00FF);
    for (int i = 0; i < N; i++) begin
      ot_flag = N'(1) << i; step(); step();
      ot_flag = '0; step();
    end
    ot_flag = 8'h01; step();
    load(16'h00FE);
    ot_flag = '0; step(); step();
    // R9: priority of over-voltage over direct inputs and sleep over all
    cur_req = "R9";
    pwm_direct = 2'b11; ov_flag = 1'b1; step(); step();
    ov_flag = 1'b0; step();
    enable_in = 1'b0; ov_flag = 1'b1; step(); step();
    enable_in = 1'b1; ov_flag = 1'b0; pwm_direct = '0;
    // R6: sleep wipes the command
    cur_req = "R6";
    wake(); step(); step();
    load(16'hFFFF);
    vdd_lost = 1'b1; step(); vdd_lost = 1'b0;
    wake(); step();
    load(16'h55AA);
    uv_flag = 1'b1; step(); step(); uv_flag = 1'b0;
    wake(); step();
    // R10: single-cycle sleep pulse mid-wake restarts the count
    cur_req = "R10";
    load(16'h0F0F);
    enable_in = 1'b0; step(); enable_in = 1'b1;
    for (int k = 0; k < RC / 2; k++) step();
    enable_in = 1'b0; step(); enable_in = 1'b1;
    wake();
    load(16'h0F0F);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule